// File: doc/BRIEF.md
# Truth-Table Bit-Serial SIMD Element Row

This block is a row of one-bit processing elements, each placed beside one memory column. Every element owns two data registers, X and Y, and a write-enable flag. An external controller broadcasts one instruction to all elements at once. The instruction carries an 8-bit truth table, and each element looks up its own result in that table, using its current memory bit and its X and Y registers as the three index bits. Any Boolean function of those three bits is therefore available in one operation. Multi-bit arithmetic is built up by the controller as a series of such operations.

Each operation takes three cycles. In the precharge cycle the shared bus rests high. In the evaluate cycle the memory bit is sampled and the lookup result is latched. In the write cycle the result goes to the selected destination. X and Y can each take the value of a neighbouring element instead of the result: X shifts toward higher element indices and Y toward lower ones, and both shifts can run in the same operation. An element whose write-enable flag is 0 issues no memory write, which gives conditional execution. While the bus tie is enabled during evaluate, the shared bus shows the AND of the controller's bus value and the results of all enabled elements, so a single low result pulls the whole bus low.

Top module: `ttpe_row`

## Requirements
- R1: After reset, X and Y of every element are 0, every write-enable flag is 1, no memory write strobe is active, and bus_level is 1.
- R2: An operation is accepted when op_valid is high while the row is idle or in its write cycle. It then runs precharge, evaluate and write for one cycle each. If op_valid is high during precharge or evaluate, it is ignored.
- R3: The result of element i is bit op_tt[{mem_rd[i], X[i], Y[i]}]. The memory bit is index bit 2, X is index bit 1 and Y is index bit 0, and the memory bit is the one present during the evaluate cycle.
- R4: The destination code selects where the result goes: 0 goes nowhere, 1 goes to X, 2 to Y, 3 to write-enable and 4 to memory, while codes 5 to 7 go nowhere. A register load takes effect at the clock edge that ends the write cycle.
- R5: During the write cycle of an operation whose destination code is 4, mem_we[i] is 1 for each enabled element and mem_wd[i] is that element's result. In every other cycle mem_we is 0.
- R6: An element whose write-enable flag is 0 issues no memory write. Its X, Y and write-enable registers can still be loaded.
- R7: With op_x_shift set, X[i] loads X[i-1], X[0] loads x_edge_in, and this takes priority over destination code 1. x_edge_out shows X[N_PE-1].
- R8: With op_y_shift set, Y[i] loads Y[i+1], Y[N_PE-1] loads y_edge_in, and this takes priority over destination code 2. y_edge_out shows Y[0]. Both shifts use pre-operation values and can run in the same operation.
- R9: bus_level is 1 in every cycle except the evaluate cycle of an operation with op_bus_tie set. In that cycle it equals ctrl_bus_in ANDed with the current result of every element whose write-enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start an operation |
| op_tt | input | 8 | Broadcast truth table |
| op_dest | input | 3 | Destination code |
| op_x_shift | input | 1 | X loads from its lower neighbour |
| op_y_shift | input | 1 | Y loads from its upper neighbour |
| op_bus_tie | input | 1 | Connect results to the shared bus during evaluate |
| mem_rd | input | N_PE | Sensed memory bit per element |
| mem_we | output | N_PE | Memory write strobe per element |
| mem_wd | output | N_PE | Memory write data per element |
| x_edge_in | input | 1 | Shift input to X of element 0 |
| y_edge_in | input | 1 | Shift input to Y of the last element |
| x_edge_out | output | 1 | X of the last element |
| y_edge_out | output | 1 | Y of element 0 |
| ctrl_bus_in | input | 1 | Controller's contribution to the bus |
| bus_level | output | 1 | Shared wired-AND bus level |
| x_plane | output | N_PE | X registers |
| y_plane | output | N_PE | Y registers |
| we_plane | output | N_PE | Write-enable flags |

## Verification
The hardest state to reach is a bus level that depends on a mixed write-enable mask. The bench first loads the flags from a memory pattern with destination code 3. It then drives patterns in which only disabled elements produce a 0, which must leave the bus high, and patterns in which an enabled element produces a 0, which must pull the bus low. A second operation is raised during precharge to show that it is ignored. Another is raised during the write cycle to show that back-to-back acceptance works.

// File: rtl/ttpe_pkg.sv
package ttpe_pkg;
  localparam int ALU_INPUTS = 3;
  localparam int TT_W       = 1 << ALU_INPUTS;
  localparam int DEST_W     = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_EVAL  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  typedef enum logic [DEST_W-1:0] {
    DST_NONE = 3'd0,
    DST_X    = 3'd1,
    DST_Y    = 3'd2,
    DST_WE   = 3'd3,
    DST_MEM  = 3'd4
  } dest_e;

  typedef struct packed {
    logic [TT_W-1:0]   tt;
    logic [DEST_W-1:0] dest;
    logic              x_shift;
    logic              y_shift;
    logic              tie;
  } instr_t;

  function automatic logic lut3(input logic [TT_W-1:0] tt,
                                input logic m, input logic x, input logic y);
    return tt[{m, x, y}];
  endfunction
endpackage

// File: rtl/ttpe_seq.sv
module ttpe_seq
  import ttpe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   op_valid,
  input  instr_t op_in,
  output phase_e phase,
  output instr_t instr
);
  phase_e phase_q, phase_d;
  instr_t instr_q;
  logic   accept;

  always_comb begin
    accept  = op_valid && ((phase_q == PH_IDLE) || (phase_q == PH_WRITE));
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (accept) phase_d = PH_PRE;
      PH_PRE:   phase_d = PH_EVAL;
      PH_EVAL:  phase_d = PH_WRITE;
      PH_WRITE: phase_d = accept ? PH_PRE : PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      instr_q <= '0;
    else if (accept) instr_q <= op_in;
  end

  assign phase = phase_q;
  assign instr = instr_q;

  AST_PRE_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PRE) |=> (phase_q == PH_EVAL)); // R2
  AST_EVAL_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EVAL) |=> (phase_q == PH_WRITE)); // R2
  AST_INSTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_PRE) || (phase_q == PH_EVAL)) |=> $stable(instr_q)); // R2
endmodule

// File: rtl/ttpe_cell.sv
module ttpe_cell
  import ttpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic              write,
  input  logic [TT_W-1:0]   tt,
  input  logic [DEST_W-1:0] dest,
  input  logic              x_shift,
  input  logic              y_shift,
  input  logic              mem_bit,
  input  logic              x_from_nbr,
  input  logic              y_from_nbr,
  output logic              alu_out,
  output logic              x_q,
  output logic              y_q,
  output logic              we_q,
  output logic              mem_we,
  output logic              mem_wd
);
  logic res_q;
  logic x_d, y_d, we_d;
  logic x_en, y_en, we_en;

  always_comb alu_out = lut3(tt, mem_bit, x_q, y_q);

  always_comb begin
    x_en  = write && (x_shift || (dest == DST_X));
    y_en  = write && (y_shift || (dest == DST_Y));
    we_en = write && (dest == DST_WE);
    x_d   = x_shift ? x_from_nbr : res_q;
    y_d   = y_shift ? y_from_nbr : res_q;
    we_d  = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= 1'b0;
    else if (eval) res_q <= alu_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= 1'b0;
      y_q  <= 1'b0;
      we_q <= 1'b1;
    end else begin
      if (x_en)  x_q  <= x_d;
      if (y_en)  y_q  <= y_d;
      if (we_en) we_q <= we_d;
    end
  end

  always_comb begin
    mem_we = write && (dest == DST_MEM) && we_q;
    mem_wd = res_q;
  end

  AST_REGS_HOLD_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !write |=> ($stable(x_q) && $stable(y_q) && $stable(we_q))); // R4
  AST_X_SHIFT_TAKES_NBR: assert property (@(posedge clk) disable iff (!rst_n)
    (write && x_shift) |=> (x_q == $past(x_from_nbr))); // R7
  AST_Y_SHIFT_TAKES_NBR: assert property (@(posedge clk) disable iff (!rst_n)
    (write && y_shift) |=> (y_q == $past(y_from_nbr))); // R8
endmodule

// File: rtl/ttpe_bus.sv
module ttpe_bus #(
  parameter int N_PE = 8
) (
  input  logic            eval,
  input  logic            tie,
  input  logic            ctrl_bus_in,
  input  logic [N_PE-1:0] alu,
  input  logic [N_PE-1:0] we,
  output logic            bus_level
);
  logic [N_PE-1:0] pull_low;

  for (genvar i = 0; i < N_PE; i++) begin : g_tap
    assign pull_low[i] = eval && tie && we[i] && !alu[i];
  end

  always_comb begin
    bus_level = !(|pull_low);
    if (eval && tie && !ctrl_bus_in) bus_level = 1'b0;
  end
endmodule

// File: rtl/ttpe_row.sv
module ttpe_row
  import ttpe_pkg::*;
#(
  parameter int N_PE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [TT_W-1:0]   op_tt,
  input  logic [DEST_W-1:0] op_dest,
  input  logic              op_x_shift,
  input  logic              op_y_shift,
  input  logic              op_bus_tie,
  input  logic [N_PE-1:0]   mem_rd,
  output logic [N_PE-1:0]   mem_we,
  output logic [N_PE-1:0]   mem_wd,
  input  logic              x_edge_in,
  input  logic              y_edge_in,
  output logic              x_edge_out,
  output logic              y_edge_out,
  input  logic              ctrl_bus_in,
  output logic              bus_level,
  output logic [N_PE-1:0]   x_plane,
  output logic [N_PE-1:0]   y_plane,
  output logic [N_PE-1:0]   we_plane
);
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  instr_t op_bundle, instr;
  phase_e phase;
  logic   ph_eval, ph_write;

  always_comb begin
    op_bundle.tt      = op_tt;
    op_bundle.dest    = op_dest;
    op_bundle.x_shift = op_x_shift;
    op_bundle.y_shift = op_y_shift;
    op_bundle.tie     = op_bus_tie;
    ph_eval  = (phase == PH_EVAL);
    ph_write = (phase == PH_WRITE);
  end

  ttpe_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int),
    .op_valid (op_valid),
    .op_in    (op_bundle),
    .phase    (phase),
    .instr    (instr)
  );

  logic [N_PE-1:0] alu, x_nbr, y_nbr;

  for (genvar i = 0; i < N_PE; i++) begin : g_pe
    if (i == 0) begin : g_xlo
      assign x_nbr[i] = x_edge_in;
    end else begin : g_xin
      assign x_nbr[i] = x_plane[i-1];
    end
    if (i == N_PE - 1) begin : g_yhi
      assign y_nbr[i] = y_edge_in;
    end else begin : g_yin
      assign y_nbr[i] = y_plane[i+1];
    end

    ttpe_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_int),
      .eval       (ph_eval),
      .write      (ph_write),
      .tt         (instr.tt),
      .dest       (instr.dest),
      .x_shift    (instr.x_shift),
      .y_shift    (instr.y_shift),
      .mem_bit    (mem_rd[i]),
      .x_from_nbr (x_nbr[i]),
      .y_from_nbr (y_nbr[i]),
      .alu_out    (alu[i]),
      .x_q        (x_plane[i]),
      .y_q        (y_plane[i]),
      .we_q       (we_plane[i]),
      .mem_we     (mem_we[i]),
      .mem_wd     (mem_wd[i])
    );
  end

  ttpe_bus #(.N_PE(N_PE)) u_bus (
    .eval        (ph_eval),
    .tie         (instr.tie),
    .ctrl_bus_in (ctrl_bus_in),
    .alu         (alu),
    .we          (we_plane),
    .bus_level   (bus_level)
  );

  assign x_edge_out = x_plane[N_PE-1];
  assign y_edge_out = y_plane[0];

  AST_BUS_HIGH_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_int)
    (phase == PH_PRE) |-> bus_level); // R9
  AST_MEM_WRITE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_int)
    (|mem_we) |-> (phase == PH_WRITE)); // R5
  AST_DISABLED_NO_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_int)
    ((mem_we & ~we_plane) == '0)); // R6
endmodule

// File: tb/tb_ttpe_row.sv
`timescale 1ns/1ps
module tb_ttpe_row;
  import ttpe_pkg::*;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid, op_x_shift, op_y_shift, op_bus_tie;
  logic [7:0] op_tt;
  logic [2:0] op_dest;
  logic [NP-1:0] mem_rd, mem_we, mem_wd, x_plane, y_plane, we_plane;
  logic x_edge_in, y_edge_in, x_edge_out, y_edge_out, ctrl_bus_in, bus_level;

  always #2 clk = ~clk;

  ttpe_row #(.N_PE(NP)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_tt(op_tt), .op_dest(op_dest),
    .op_x_shift(op_x_shift), .op_y_shift(op_y_shift), .op_bus_tie(op_bus_tie),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_wd(mem_wd),
    .x_edge_in(x_edge_in), .y_edge_in(y_edge_in), .x_edge_out(x_edge_out),
    .y_edge_out(y_edge_out), .ctrl_bus_in(ctrl_bus_in), .bus_level(bus_level),
    .x_plane(x_plane), .y_plane(y_plane), .we_plane(we_plane)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic ob_pre, ob_eval;
  logic [NP-1:0] ob_mwe, ob_mwd;

  // fields: tt[19:12] x[11:8] y[7:4] mem[3:0]
  localparam logic [19:0] VEC [8] = '{
    {8'hF0, 4'hA, 4'h5, 4'h3}, {8'hCC, 4'hA, 4'h5, 4'h3},
    {8'hAA, 4'h6, 4'h9, 4'hC}, {8'h96, 4'h3, 4'h5, 4'hF},
    {8'hE8, 4'hC, 4'hA, 4'h6}, {8'h01, 4'h1, 4'h2, 4'h4},
    {8'h80, 4'hF, 4'h7, 4'hB}, {8'h6C, 4'h9, 4'h3, 4'h5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] tt, input logic [2:0] dst, input logic xs,
                       input logic ys, input logic tie, input logic [NP-1:0] m,
                       input logic cb);
    @(negedge clk);
    op_valid = 1'b1; op_tt = tt; op_dest = dst; op_x_shift = xs; op_y_shift = ys;
    op_bus_tie = tie; mem_rd = m; ctrl_bus_in = cb;
    @(negedge clk); op_valid = 1'b0; ob_pre = bus_level;
    @(negedge clk); ob_eval = bus_level;
    @(negedge clk); ob_mwe = mem_we; ob_mwd = mem_wd;
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] lookup(input logic [7:0] tt, input logic [NP-1:0] x,
                                           input logic [NP-1:0] y, input logic [NP-1:0] m);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = tt[{m[i], x[i], y[i]}];
    return r;
  endfunction

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] xv, yv, wv;
    rst_n = 1'b0; op_valid = 0; op_tt = 0; op_dest = 0; op_x_shift = 0; op_y_shift = 0;
    op_bus_tie = 0; mem_rd = 0; x_edge_in = 0; y_edge_in = 0; ctrl_bus_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 x", x_plane, 0); check("R1 y", y_plane, 0);
    check("R1 we", we_plane, 4'hF); check("R1 mem_we", mem_we, 0);
    check("R1 bus", bus_level, 1);

    // R3 / R5 vector table
    for (int v = 0; v < 8; v++) begin
      do_op(8'hF0, DST_X, 0, 0, 0, VEC[v][11:8], 1);
      do_op(8'hF0, DST_Y, 0, 0, 0, VEC[v][7:4], 1);
      check("R4 x load", x_plane, VEC[v][11:8]);
      check("R4 y load", y_plane, VEC[v][7:4]);
      do_op(VEC[v][19:12], DST_MEM, 0, 0, 0, VEC[v][3:0], 1);
      check("R3 result", ob_mwd, lookup(VEC[v][19:12], VEC[v][11:8], VEC[v][7:4], VEC[v][3:0]));
      check("R5 mem_we", ob_mwe, 4'hF);
    end

    // R4 unused destination codes change nothing
    xv = x_plane; yv = y_plane;
    for (int d = 5; d < 8; d++) begin
      do_op(8'hFF, 3'(d), 0, 0, 0, 4'h0, 1);
      check("R4 unused x", x_plane, xv); check("R4 unused y", y_plane, yv);
      check("R4 unused we", we_plane, 4'hF); check("R4 unused mem_we", ob_mwe, 0);
    end
    do_op(8'hFF, DST_NONE, 0, 0, 0, 4'h0, 1);
    check("R4 none x", x_plane, xv); check("R5 none mem_we", ob_mwe, 0);

    // R2 op ignored during precharge
    do_op(8'hF0, DST_Y, 0, 0, 0, 4'h0, 1);
    @(negedge clk);
    op_valid = 1; op_tt = 8'hF0; op_dest = DST_X; op_x_shift = 0; op_y_shift = 0;
    op_bus_tie = 0; mem_rd = 4'hF;
    @(negedge clk); op_valid = 1; op_tt = 8'hFF; op_dest = DST_Y;   // in PRE
    @(negedge clk); op_valid = 0;                                    // EVAL
    @(negedge clk); @(negedge clk);
    repeat (4) @(negedge clk);
    check("R2 ignored y", y_plane, 4'h0);
    check("R2 first x", x_plane, 4'hF);

    // R2 back-to-back accepted in write cycle
    @(negedge clk);
    op_valid = 1; op_tt = 8'hF0; op_dest = DST_X; mem_rd = 4'h3;
    @(negedge clk); op_valid = 0;
    @(negedge clk);
    @(negedge clk); op_valid = 1; op_dest = DST_Y; mem_rd = 4'hC;     // WRITE
    @(negedge clk); op_valid = 0;
    check("R2 b2b x", x_plane, 4'h3);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R2 b2b y", y_plane, 4'hC);

    // R7 / R8 shifts, both at once, over destination
    do_op(8'hF0, DST_X, 0, 0, 0, 4'h9, 1);
    do_op(8'hF0, DST_Y, 0, 0, 0, 4'h6, 1);
    check("R7 x_edge_out", x_edge_out, 1); check("R8 y_edge_out", y_edge_out, 0);
    x_edge_in = 1; y_edge_in = 0;
    do_op(8'hFF, DST_X, 1, 1, 0, 4'h0, 1);
    check("R7 x shift", x_plane, 4'h3); check("R8 y shift", y_plane, 4'h3);
    x_edge_in = 0; y_edge_in = 1;
    do_op(8'h00, DST_Y, 1, 1, 0, 4'h0, 1);
    check("R7 x shift2", x_plane, 4'h6); check("R8 y shift2", y_plane, 4'h9);

    // R6 write-enable masking
    do_op(8'hF0, DST_WE, 0, 0, 0, 4'h5, 1);
    check("R4 we load", we_plane, 4'h5);
    do_op(8'hFF, DST_MEM, 0, 0, 0, 4'h0, 1);
    check("R6 mem_we masked", ob_mwe, 4'h5); check("R5 wd", ob_mwd, 4'hF);
    do_op(8'hF0, DST_X, 0, 0, 0, 4'hF, 1);
    check("R6 x still loads", x_plane, 4'hF);

    // R9 bus with mask 0101
    wv = we_plane;
    do_op(8'hF0, DST_NONE, 0, 0, 1, 4'hA, 1);
    check("R9 pre", ob_pre, 1);
    check("R9 low from enabled", ob_eval, 1'(&(4'hA | ~wv)));
    do_op(8'hF0, DST_NONE, 0, 0, 1, 4'h5, 1);
    check("R9 disabled zeros ignored", ob_eval, 1);
    do_op(8'hF0, DST_NONE, 0, 0, 1, 4'h5, 0);
    check("R9 ctrl low", ob_eval, 0);
    do_op(8'hF0, DST_NONE, 0, 0, 0, 4'h0, 0);
    check("R9 tie off", ob_eval, 1);
    do_op(8'hFF, DST_WE, 0, 0, 0, 4'h0, 1);
    check("R6 we reload", we_plane, 4'hF);

    // R1 reset mid-operation
    @(negedge clk);
    op_valid = 1; op_tt = 8'hFF; op_dest = DST_MEM; mem_rd = 4'h0;
    @(negedge clk); op_valid = 0; rst_n = 0;
    @(negedge clk);
    check("R1 async x", x_plane, 0); check("R1 async mem_we", mem_we, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check("R1 after op", we_plane, 4'hF); check("R1 bus after", bus_level, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule